// File: doc/BRIEF.md
# Secure Mode Trap Controller

This block decides when the processor must be pulled into a protected kernel. It holds one control and status word on a simple register bus. It also decodes the boot address window into chip selects. The block tracks one flag, the secure-mode state. While that flag is low, the following all force entry into secure mode: any access to the word, a timer expiry, an interface error from either bus side, a power-button press or removal of the removable memory card. Each of these raises a one-cycle non-maskable interrupt (NMI) and records the reason in a cause field. A read from unprivileged code counts as a syscall and has its own cause bit.

While the flag is high, the kernel owns the word. It can clear causes, choose which of two 128 KiB regions answers at the low boot address, open a 32 KiB scratch RAM window, set a free flag for its own use and finally drop the secure flag to return to normal code. The decoder turns a memory request address into one of three chip selects: boot ROM, kernel ROM or scratch RAM.

Top module: `secure_trap_ctrl`

## Requirements
- R1: After reset the word reads 0x00000001: secure mode on, every cause clear, swap bit 1 at 0, RAM enable bit 24 at 0, free flag bit 25 at 0. The NMI output is low.
- R2: A write made in secure mode loads bit 0 into the secure flag. Writing 0 leaves secure mode, and `secure_mode` goes low in the cycle after the write.
- R3: Any read or write of the word while not in secure mode produces an NMI exactly one cycle wide. The secure flag rises in the same cycle as that pulse.
- R4: A read of the word while not in secure mode sets the syscall cause, bit 2.
- R5: An event while not in secure mode sets its cause bit, raises the NMI and enters secure mode. The cause bits are: timer at bit 3, peripheral-bus error at bit 4, processor-bus error at bit 5, power button at bit 6, card removal at bit 7.
- R6: An event while in secure mode sets its cause bit but produces no NMI.
- R7: In secure mode, writing 1 to a cause bit clears it and writing 0 leaves it unchanged. If an event for that bit arrives in the same cycle as the clear, the bit stays set.
- R8: A write while not in secure mode changes no field of the word. It only traps.
- R9: With bit 1 at 0, addresses in 0x1FC00000–0x1FC1FFFF select the kernel ROM and 0x1FC20000–0x1FC3FFFF select the boot ROM. With bit 1 at 1, the two ranges swap. No more than one chip select is ever active, and none is active without `mem_req`.
- R10: Addresses in 0x1FC40000–0x1FC47FFF select the scratch RAM only while bit 24 is 1. Otherwise that range selects nothing.
- R11: Bit 25 reads back what secure code wrote to it. It has no effect on the NMI or on the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read of the word is strobed |
| ev_timer | input | 1 | Timer expiry event |
| ev_pi_err | input | 1 | Peripheral-bus error event |
| ev_mi_err | input | 1 | Processor-bus error event |
| ev_button | input | 1 | Power-button press event |
| ev_card_out | input | 1 | Memory card removal event |
| mem_req | input | 1 | Memory request valid |
| mem_addr | input | 32 | Memory request address |
| cs_boot | output | 1 | Boot ROM chip select |
| cs_kernel | output | 1 | Kernel ROM chip select |
| cs_sram | output | 1 | Scratch RAM chip select |
| nmi | output | 1 | Non-maskable interrupt pulse |
| secure_mode | output | 1 | Current secure-mode flag |

## Verification
The collision of interest is a kernel write that clears a cause bit in the same cycle as a fresh event for that bit. The event must win, so that no trap reason is lost. The bench drives the write strobe and the button event on the same falling edge, together with a clear of a second, idle cause. After the edge, a read-back must show the contested bit still set and the idle bit gone. A second overlap is a trap that lands in the cycle secure mode is entered. This is judged by checking that the NMI and the secure flag turn up at the same sample and that no further pulse follows.

// File: rtl/secure_trap_ctrl.sv
module secure_trap_ctrl #(
  parameter int                BUS_AW     = 8,
  parameter logic [BUS_AW-1:0] CSR_ADDR   = 8'h14,
  parameter int                MEM_AW     = 32,
  parameter logic [MEM_AW-1:0] LOW_BASE   = 32'h1FC0_0000,
  parameter logic [MEM_AW-1:0] HIGH_BASE  = 32'h1FC2_0000,
  parameter logic [MEM_AW-1:0] SRAM_BASE  = 32'h1FC4_0000,
  parameter int                ROM_BITS   = 17,
  parameter int                SRAM_BITS  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_timer,
  input  logic              ev_pi_err,
  input  logic              ev_mi_err,
  input  logic              ev_button,
  input  logic              ev_card_out,
  input  logic              mem_req,
  input  logic [MEM_AW-1:0] mem_addr,
  output logic              cs_boot,
  output logic              cs_kernel,
  output logic              cs_sram,
  output logic              nmi,
  output logic              secure_mode
);

  logic       secure_q, swap_q, ram_en_q, app_q, nmi_q;
  logic [5:0] cause_q;

  logic       hit, rd_hit, wr_hit, sec_wr, any_trap;
  logic [4:0] ev_vec;
  logic [5:0] set_vec, clr_vec;

  assign hit      = (bus_addr == CSR_ADDR);
  assign rd_hit   = hit & bus_rd;
  assign wr_hit   = hit & bus_wr;
  assign sec_wr   = wr_hit & secure_q;
  assign ev_vec   = {ev_card_out, ev_button, ev_mi_err, ev_pi_err, ev_timer};
  assign set_vec  = {ev_vec, rd_hit & ~secure_q};
  assign clr_vec  = sec_wr ? bus_wdata[7:2] : 6'b0;
  assign any_trap = ~secure_q & (rd_hit | wr_hit | (|ev_vec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secure_q <= 1'b1;
      swap_q   <= 1'b0;
      ram_en_q <= 1'b0;
      app_q    <= 1'b0;
      nmi_q    <= 1'b0;
      cause_q  <= '0;
    end else begin
      nmi_q   <= any_trap;
      cause_q <= (cause_q & ~clr_vec) | set_vec;
      if (sec_wr) begin
        secure_q <= bus_wdata[0];
        swap_q   <= bus_wdata[1];
        ram_en_q <= bus_wdata[24];
        app_q    <= bus_wdata[25];
      end else if (any_trap) begin
        secure_q <= 1'b1;
      end
    end
  end

  assign bus_rdata   = rd_hit ? {6'b0, app_q, ram_en_q, 16'b0, cause_q, swap_q, secure_q} : 32'b0;
  assign nmi         = nmi_q;
  assign secure_mode = secure_q;

  logic low_hit, high_hit, sram_hit;
  assign low_hit   = mem_addr[MEM_AW-1:ROM_BITS]  == LOW_BASE[MEM_AW-1:ROM_BITS];
  assign high_hit  = mem_addr[MEM_AW-1:ROM_BITS]  == HIGH_BASE[MEM_AW-1:ROM_BITS];
  assign sram_hit  = mem_addr[MEM_AW-1:SRAM_BITS] == SRAM_BASE[MEM_AW-1:SRAM_BITS];
  assign cs_kernel = mem_req & (swap_q ? high_hit : low_hit);
  assign cs_boot   = mem_req & (swap_q ? low_hit : high_hit);
  assign cs_sram   = mem_req & sram_hit & ram_en_q;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:26], bus_wdata[23:8], mem_addr[SRAM_BITS-1:0]};

  // R3
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);

  // R3
  nmi_enters_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure_mode && (rd_hit || wr_hit)) |=> (nmi && secure_mode));

  // R6
  no_nmi_in_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    secure_mode |=> !nmi);

  // R4
  syscall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure_mode && rd_hit) |=> cause_q[0]);

  // R8
  ns_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!secure_mode && wr_hit) |=> ($stable(swap_q) && $stable(ram_en_q) && $stable(app_q)));

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_boot, cs_kernel, cs_sram}));

  // R10
  sram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && sram_hit && !ram_en_q) |-> !cs_sram);

endmodule

// File: tb/tb_secure_trap_ctrl.sv
`timescale 1ns/1ps
module tb_secure_trap_ctrl;

  localparam logic [7:0] CSR = 8'h14;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = CSR;
  logic        bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        ev_timer = 0, ev_pi_err = 0, ev_mi_err = 0, ev_button = 0, ev_card_out = 0;
  logic        mem_req = 0;
  logic [31:0] mem_addr = 0;
  logic        cs_boot, cs_kernel, cs_sram, nmi, secure_mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  secure_trap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_timer(ev_timer), .ev_pi_err(ev_pi_err),
    .ev_mi_err(ev_mi_err), .ev_button(ev_button), .ev_card_out(ev_card_out),
    .mem_req(mem_req), .mem_addr(mem_addr), .cs_boot(cs_boot), .cs_kernel(cs_kernel),
    .cs_sram(cs_sram), .nmi(nmi), .secure_mode(secure_mode));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd_word(output logic [31:0] d);
    @(negedge clk); bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic sel(input logic [31:0] a, output logic [2:0] cs);
    mem_req = 1; mem_addr = a; #1 cs = {cs_boot, cs_kernel, cs_sram};
    mem_req = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 nmi", {31'b0, nmi}, 0);
    check("R1 secure", {31'b0, secure_mode}, 1);
    rd_word(v);
    check("R1 word", v, 32'h1);
  endtask

  task automatic t_exit();
    wr_word(32'h0);
    check("R2 secure low", {31'b0, secure_mode}, 0);
    check("R2 no nmi", {31'b0, nmi}, 0);
  endtask

  task automatic t_ns_read();
    logic [31:0] v;
    rd_word(v);
    check("R3 nmi pulse", {31'b0, nmi}, 1);
    check("R3 secure same cycle", {31'b0, secure_mode}, 1);
    @(negedge clk);
    check("R3 nmi one cycle", {31'b0, nmi}, 0);
    rd_word(v);
    check("R4 syscall cause", v, 32'h5);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr_word(32'h5);
    rd_word(v);
    check("R7 clear syscall", v, 32'h1);
  endtask

  task automatic t_event_ns();
    logic [31:0] v;
    wr_word(32'h0);
    @(negedge clk); ev_timer = 1;
    @(negedge clk); ev_timer = 0;
    check("R5 timer nmi", {31'b0, nmi}, 1);
    check("R5 timer secure", {31'b0, secure_mode}, 1);
    rd_word(v);
    check("R5 timer cause bit3", v, 32'h9);
    wr_word(32'h8);
    @(negedge clk); ev_card_out = 1;
    @(negedge clk); ev_card_out = 0;
    check("R5 card nmi", {31'b0, nmi}, 1);
    rd_word(v);
    check("R5 card cause bit7", v, 32'h81);
    wr_word(32'h81);
  endtask

  task automatic t_event_sec();
    logic [31:0] v;
    bit seen = 0;
    @(negedge clk); ev_button = 1; ev_mi_err = 1;
    @(negedge clk); ev_button = 0; ev_mi_err = 0;
    if (nmi) seen = 1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (nmi) seen = 1; end
    check("R6 no nmi in secure", {31'b0, seen}, 0);
    rd_word(v);
    check("R6 causes latched", v, 32'h61);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    @(negedge clk); bus_wr = 1; bus_wdata = 32'h61; ev_button = 1;
    @(negedge clk); bus_wr = 0; bus_wdata = 0; ev_button = 0;
    rd_word(v);
    check("R7 event beats clear", v, 32'h41);
    wr_word(32'h41);
  endtask

  task automatic t_ns_write();
    logic [31:0] v;
    wr_word(32'h0100_0003);
    wr_word(32'h0100_0002);
    check("R2 exit keeps fields", {31'b0, secure_mode}, 0);
    wr_word(32'h0200_00FD);
    check("R3 write nmi", {31'b0, nmi}, 1);
    check("R3 write secure", {31'b0, secure_mode}, 1);
    rd_word(v);
    check("R8 ns write ignored", v, 32'h0100_0003);
  endtask

  task automatic t_decode();
    logic [2:0] cs;
    sel(32'h1FC0_0010, cs); check("R9 swap1 low->boot", {29'b0, cs}, 3'b100);
    sel(32'h1FC2_0010, cs); check("R9 swap1 high->kernel", {29'b0, cs}, 3'b010);
    sel(32'h1FC4_0010, cs); check("R10 ram open", {29'b0, cs}, 3'b001);
    sel(32'h1FC4_8000, cs); check("R10 past ram end", {29'b0, cs}, 3'b000);
    mem_addr = 32'h1FC0_0010; #1;
    check("R9 no req", {29'b0, cs_boot, cs_kernel, cs_sram}, 3'b000);
    wr_word(32'h1);
    sel(32'h1FC0_0010, cs); check("R9 swap0 low->kernel", {29'b0, cs}, 3'b010);
    sel(32'h1FC2_0010, cs); check("R9 swap0 high->boot", {29'b0, cs}, 3'b100);
    sel(32'h1FC4_0010, cs); check("R10 ram closed", {29'b0, cs}, 3'b000);
  endtask

  task automatic t_app_flag();
    logic [31:0] v;
    logic [2:0] cs;
    wr_word(32'h0200_0001);
    check("R11 no nmi", {31'b0, nmi}, 0);
    rd_word(v);
    check("R11 flag reads back", v, 32'h0200_0001);
    sel(32'h1FC4_0010, cs); check("R11 no ram effect", {29'b0, cs}, 3'b000);
    sel(32'h1FC0_0010, cs); check("R11 no swap effect", {29'b0, cs}, 3'b010);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_exit();
    t_ns_read();
    t_w1c();
    t_event_ns();
    t_event_sec();
    t_collision();
    t_ns_write();
    t_decode();
    t_app_flag();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule